// File: doc/BRIEF.md
# Multidrop Address Wake/Doze Filter

This block sits between a serial receiver's character output and the receive FIFO in a multidrop link. On such a link each character carries an extra flag. When the flag is set the character is an address, and when it is clear the character is data. The filter keeps a receiver-enabled state. While the receiver is disabled, data characters are dropped and address characters may still pass. While it is enabled, data characters pass. The flag itself is written into the status slot that would normally hold parity error, so software reading the FIFO can tell which characters were addresses.

A 2-bit mode field lets the block change the enabled state by itself, with no host action. Bit 0 is the wake option: an address equal to the reference character turns the receiver on. Bit 1 is the doze option: an address that differs from the reference turns the receiver off. When either option acts on a character, the block records an address event. That event drives a maskable interrupt. A host clear command or a receiver reset removes the event. With both mode bits clear, only the host commands change the enabled state.

Top module: `mdrop_wake_filter`

## Requirements
- R1: After reset `rx_enabled`, `push_valid`, `addr_event`, `irq` and `rx_overrun` are all 0.
- R2: A character that is kept appears on `push_valid` one cycle after its `rx_valid` strobe, with `push_data` equal to the character. The status bits are `push_status[0]` = framing error, `push_status[1]` = address flag (the parity slot) and `push_status[2]` = break.
- R3: While `rx_enabled` is 1 every data character (`rx_addr_flag`=0) is kept. While it is 0, every data character is dropped.
- R4: With `cfg_wake_mode`=00, address characters are always kept. With a nonzero mode, address characters are kept only if `cfg_keep_addr`=1. This holds whatever the enabled state is.
- R5: With `cfg_wake_mode`=00, received characters never change `rx_enabled`. Only `host_enable`, `host_disable` and `host_rx_reset` change it.
- R6: With `cfg_wake_mode[0]`=1, an address character equal to `cfg_ref_char` sets `rx_enabled` on the clock edge that samples its strobe.
- R7: With `cfg_wake_mode[1]`=1, an address character that differs from `cfg_ref_char` clears `rx_enabled` on the same edge.
- R8: Under wake only, a non-matching address leaves the state unchanged. Under doze only, a matching address leaves the state unchanged. Data characters never change the state.
- R9: When commands and a character act in the same cycle, the order of precedence is `host_rx_reset`, then `host_disable`, then `host_enable`, then the character's wake or doze action.
- R10: A wake or doze action sets `addr_event`, even if the state was already the target state. `host_clr_irq` clears `addr_event`, but a new action in the same cycle wins. `host_rx_reset` clears it. `irq` is `addr_event AND NOT cfg_irq_mask`, registered from the mask at the same edge.
- R11: A kept character that arrives while `fifo_full`=1 is not pushed and sets the sticky `rx_overrun`. Only `host_rx_reset` clears `rx_overrun`. The enabled state and the event are still updated for that character.
- R12: Framing and break flags are carried on every kept character, whether or not the receiver is enabled. A character in the same cycle as `host_rx_reset` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ref_char | input | DW | Reference address character |
| cfg_wake_mode | input | 2 | Bit 0 wake on match, bit 1 doze on mismatch |
| cfg_keep_addr | input | 1 | Keep address characters in auto modes |
| cfg_irq_mask | input | 1 | 1 masks the address interrupt |
| rx_valid | input | 1 | Character strobe |
| rx_data | input | DW | Received character |
| rx_addr_flag | input | 1 | 1 = address character |
| rx_frame_err | input | 1 | Framing error for this character |
| rx_break | input | 1 | Break detected for this character |
| host_enable | input | 1 | Host enable command |
| host_disable | input | 1 | Host disable command |
| host_clr_irq | input | 1 | Clear pending address event |
| host_rx_reset | input | 1 | Receiver reset command |
| fifo_full | input | 1 | Receive FIFO has no room |
| push_valid | output | 1 | FIFO write strobe |
| push_data | output | DW | FIFO write data |
| push_status | output | 3 | {break, address flag, framing} |
| rx_enabled | output | 1 | Receiver enabled state |
| addr_event | output | 1 | Pending address event |
| irq | output | 1 | Address interrupt request |
| rx_overrun | output | 1 | Sticky overrun flag |

## Verification
A wrong enable state appears one cycle after the next data character. That character is pushed when it should be dropped, or dropped when it should be pushed. The error also shows directly on `rx_enabled` at the edge after the address that caused it. A wrong event or mask path shows on `irq` at the same edge as the address that acted. A lost overrun shows on the next full-FIFO character. Random traffic that often repeats the reference character reaches all four mode settings quickly, and every output is compared every cycle.

// File: rtl/mdwf_pkg.sv
package mdwf_pkg;
  localparam int STAT_W = 3;
  localparam int ST_FRM = 0;
  localparam int ST_ADR = 1;
  localparam int ST_BRK = 2;

  typedef struct packed {
    logic brk;
    logic adr;
    logic frm;
  } mdwf_stat_t;

  typedef enum logic {RX_OFF = 1'b0, RX_ON = 1'b1} rx_state_e;
endpackage

// File: rtl/mdwf_addr_cmp.sv
module mdwf_addr_cmp #(
  parameter int DW = 8
) (
  input  logic          valid,
  input  logic          addr_flag,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] ref_char,
  input  logic [1:0]    mode,
  output logic          act_wake,
  output logic          act_doze
);
  logic [DW-1:0] bit_eq;
  logic          match;
  logic          is_addr;

  genvar g;
  generate
    for (g = 0; g < DW; g++) begin : g_bit
      assign bit_eq[g] = ~(data[g] ^ ref_char[g]);
    end
  endgenerate

  assign match    = &bit_eq;
  assign is_addr  = valid & addr_flag;
  assign act_wake = is_addr & mode[0] & match;
  assign act_doze = is_addr & mode[1] & ~match;
endmodule

// File: rtl/mdwf_en_fsm.sv
module mdwf_en_fsm
  import mdwf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rx_reset,
  input  logic host_en,
  input  logic host_dis,
  input  logic act_wake,
  input  logic act_doze,
  output logic en
);
  rx_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (rx_reset)      st_d = RX_OFF;
    else if (host_dis) st_d = RX_OFF;
    else if (host_en)  st_d = RX_ON;
    else if (act_wake) st_d = RX_ON;
    else if (act_doze) st_d = RX_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= RX_OFF;
    else     st_q <= st_d;
  end

  assign en = (st_q == RX_ON);
endmodule

// File: rtl/mdwf_push_stage.sv
module mdwf_push_stage
  import mdwf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [DW-1:0]     data,
  input  logic              addr_flag,
  input  logic              frm,
  input  logic              brk,
  input  logic              en_cur,
  input  logic [1:0]        mode,
  input  logic              keep_addr,
  input  logic              full,
  input  logic              rx_reset,
  output logic              push_valid,
  output logic [DW-1:0]     push_data,
  output logic [STAT_W-1:0] push_status,
  output logic              overrun
);
  logic       cand;
  logic       keep_a;
  mdwf_stat_t stat_d;

  assign keep_a = (mode == 2'b00) | keep_addr;
  assign cand   = valid & (addr_flag ? keep_a : en_cur);

  always_comb begin
    stat_d.brk = brk;
    stat_d.adr = addr_flag;
    stat_d.frm = frm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      push_valid  <= 1'b0;
      push_data   <= '0;
      push_status <= '0;
      overrun     <= 1'b0;
    end else begin
      push_valid <= cand & ~full & ~rx_reset;
      if (cand) begin
        push_data   <= data;
        push_status <= stat_d;
      end
      if (rx_reset)         overrun <= 1'b0;
      else if (cand & full) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/mdwf_irq_ctl.sv
module mdwf_irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic rx_reset,
  input  logic evt,
  input  logic clr,
  input  logic mask,
  output logic pending,
  output logic irq
);
  logic pend_d;

  always_comb begin
    pend_d = pending;
    if (rx_reset) pend_d = 1'b0;
    else if (evt) pend_d = 1'b1;
    else if (clr) pend_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      irq     <= 1'b0;
    end else begin
      pending <= pend_d;
      irq     <= pend_d & ~mask;
    end
  end
endmodule

// File: rtl/mdrop_wake_filter.sv
module mdrop_wake_filter
  import mdwf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DW-1:0]     cfg_ref_char,
  input  logic [1:0]        cfg_wake_mode,
  input  logic              cfg_keep_addr,
  input  logic              cfg_irq_mask,
  input  logic              rx_valid,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_addr_flag,
  input  logic              rx_frame_err,
  input  logic              rx_break,
  input  logic              host_enable,
  input  logic              host_disable,
  input  logic              host_clr_irq,
  input  logic              host_rx_reset,
  input  logic              fifo_full,
  output logic              push_valid,
  output logic [DW-1:0]     push_data,
  output logic [STAT_W-1:0] push_status,
  output logic              rx_enabled,
  output logic              addr_event,
  output logic              irq,
  output logic              rx_overrun
);
  logic act_wake, act_doze;

  mdwf_addr_cmp #(.DW(DW)) cmp_i (
    .valid     (rx_valid),
    .addr_flag (rx_addr_flag),
    .data      (rx_data),
    .ref_char  (cfg_ref_char),
    .mode      (cfg_wake_mode),
    .act_wake  (act_wake),
    .act_doze  (act_doze)
  );

  mdwf_en_fsm fsm_i (
    .clk      (clk),
    .rst      (rst),
    .rx_reset (host_rx_reset),
    .host_en  (host_enable),
    .host_dis (host_disable),
    .act_wake (act_wake),
    .act_doze (act_doze),
    .en       (rx_enabled)
  );

  mdwf_push_stage #(.DW(DW)) push_i (
    .clk         (clk),
    .rst         (rst),
    .valid       (rx_valid),
    .data        (rx_data),
    .addr_flag   (rx_addr_flag),
    .frm         (rx_frame_err),
    .brk         (rx_break),
    .en_cur      (rx_enabled),
    .mode        (cfg_wake_mode),
    .keep_addr   (cfg_keep_addr),
    .full        (fifo_full),
    .rx_reset    (host_rx_reset),
    .push_valid  (push_valid),
    .push_data   (push_data),
    .push_status (push_status),
    .overrun     (rx_overrun)
  );

  mdwf_irq_ctl irq_i (
    .clk      (clk),
    .rst      (rst),
    .rx_reset (host_rx_reset),
    .evt      (act_wake | act_doze),
    .clr      (host_clr_irq),
    .mask     (cfg_irq_mask),
    .pending  (addr_event),
    .irq      (irq)
  );
endmodule

// File: rtl/mdwf_checker.sv
module mdwf_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] cfg_ref_char,
  input logic [1:0]    cfg_wake_mode,
  input logic          cfg_irq_mask,
  input logic          rx_valid,
  input logic [DW-1:0] rx_data,
  input logic          rx_addr_flag,
  input logic          host_enable,
  input logic          host_disable,
  input logic          host_rx_reset,
  input logic          fifo_full,
  input logic          push_valid,
  input logic [2:0]    push_status,
  input logic          rx_enabled,
  input logic          addr_event,
  input logic          irq,
  input logic          rx_overrun
);
  AST_PUSH_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    push_valid |-> $past(rx_valid) && !$past(fifo_full) && !$past(host_rx_reset)); // R11
  AST_ADDR_IN_PARITY_SLOT: assert property (@(posedge clk) disable iff (rst)
    push_valid |-> push_status[1] == $past(rx_addr_flag)); // R2
  AST_DATA_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !push_status[1]) |-> $past(rx_enabled)); // R3
  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (rx_enabled && !$past(rx_enabled)) |->
      ($past(host_enable) || $past(rx_valid && rx_addr_flag && cfg_wake_mode[0]
                                    && (rx_data == cfg_ref_char)))); // R6
  AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (!rx_enabled && $past(rx_enabled)) |->
      ($past(host_disable) || $past(host_rx_reset) ||
       $past(rx_valid && rx_addr_flag && cfg_wake_mode[1] && (rx_data != cfg_ref_char)))); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> addr_event && !$past(cfg_irq_mask)); // R10
  AST_RXRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(host_rx_reset) |-> !rx_enabled && !addr_event && !rx_overrun); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(rx_overrun) && !$past(host_rx_reset)) |-> rx_overrun); // R11
endmodule

bind mdrop_wake_filter mdwf_checker #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .cfg_ref_char(cfg_ref_char), .cfg_wake_mode(cfg_wake_mode),
  .cfg_irq_mask(cfg_irq_mask), .rx_valid(rx_valid), .rx_data(rx_data),
  .rx_addr_flag(rx_addr_flag), .host_enable(host_enable), .host_disable(host_disable),
  .host_rx_reset(host_rx_reset), .fifo_full(fifo_full), .push_valid(push_valid),
  .push_status(push_status), .rx_enabled(rx_enabled), .addr_event(addr_event),
  .irq(irq), .rx_overrun(rx_overrun)
);

// File: tb/mdrop_wake_filter_tb_top.sv
module mdrop_wake_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst;
  logic [DW-1:0] cfg_ref_char;
  logic [1:0] cfg_wake_mode;
  logic cfg_keep_addr, cfg_irq_mask;
  logic rx_valid, rx_addr_flag, rx_frame_err, rx_break;
  logic [DW-1:0] rx_data;
  logic host_enable, host_disable, host_clr_irq, host_rx_reset, fifo_full;
  logic push_valid;
  logic [DW-1:0] push_data;
  logic [2:0] push_status;
  logic rx_enabled, addr_event, irq, rx_overrun;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state and expectations
  logic m_en, m_ev, m_ovr;
  logic e_push, e_irq;
  logic [DW-1:0] e_data;
  logic [2:0] e_stat;
  string t_push, t_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdrop_wake_filter #(.DW(DW)) dut_i (.*);

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, got, exp, $time);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R5";
      2'b01:   return "R6";
      2'b10:   return "R7";
      default: return "R8";
    endcase
  endfunction

  // drive one cycle of stimulus and advance the model (R2..R12)
  task automatic drive(input logic v, input logic a, input logic [DW-1:0] d,
                       input logic fe, input logic br, input logic he, input logic hd,
                       input logic hc, input logic hr, input logic full);
    logic is_a, match, aw, ad, cand, keep;
    rx_valid = v; rx_addr_flag = a; rx_data = d; rx_frame_err = fe; rx_break = br;
    host_enable = he; host_disable = hd; host_clr_irq = hc; host_rx_reset = hr;
    fifo_full = full;
    is_a  = v & a;
    match = (d == cfg_ref_char);
    aw    = is_a & cfg_wake_mode[0] & match;
    ad    = is_a & cfg_wake_mode[1] & ~match;
    keep  = (cfg_wake_mode == 2'b00) | cfg_keep_addr;
    cand  = v & (a ? keep : m_en);
    e_push = cand & ~full & ~hr;
    if (cand) begin e_data = d; e_stat = {br, a, fe}; end
    t_push = full ? "R11" : (hr ? "R12" : (a ? "R4" : "R3"));
    t_en   = (hr | hd | he) ? "R9" : mode_tag(cfg_wake_mode);
    if (hr) m_ovr = 1'b0; else if (cand & full) m_ovr = 1'b1;
    if (hr) m_en = 1'b0; else if (hd) m_en = 1'b0; else if (he) m_en = 1'b1;
    else if (aw) m_en = 1'b1; else if (ad) m_en = 1'b0;
    if (hr) m_ev = 1'b0; else if (aw | ad) m_ev = 1'b1; else if (hc) m_ev = 1'b0;
    e_irq = m_ev & ~cfg_irq_mask;
  endtask

  task automatic step_and_check();
    @(negedge clk);
    chk(t_push, "push_valid", push_valid, e_push);
    if (e_push) begin
      chk("R2", "push_data", push_data, e_data);
      chk("R12", "push_status", push_status, e_stat);
    end
    chk(t_en, "rx_enabled", rx_enabled, m_en);
    chk("R10", "addr_event", addr_event, m_ev);
    chk("R10", "irq", irq, e_irq);
    chk("R11", "rx_overrun", rx_overrun, m_ovr);
  endtask

  task automatic cyc(input logic v, input logic a, input logic [DW-1:0] d,
                     input logic fe, input logic br, input logic he, input logic hd,
                     input logic hc, input logic hr, input logic full);
    drive(v, a, d, fe, br, he, hd, hc, hr, full);
    step_and_check();
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    rst = 1'b1;
    cfg_ref_char = 8'h5A; cfg_wake_mode = 2'b00; cfg_keep_addr = 1'b0; cfg_irq_mask = 1'b0;
    m_en = 0; m_ev = 0; m_ovr = 0; e_push = 0; e_irq = 0; e_data = '0; e_stat = '0;
    t_push = "R1"; t_en = "R1";
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    @(negedge clk);
    chk("R1", "rx_enabled", rx_enabled, 0);
    chk("R1", "push_valid", push_valid, 0);
    chk("R1", "addr_event", addr_event, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "rx_overrun", rx_overrun, 0);

    // R5 / R4: host mode, matching address kept but no state change
    cyc(1, 1, 8'h5A, 0, 0, 0, 0, 0, 0, 0);
    chk("R5", "enabled after match in host mode", rx_enabled, 0);
    // R3: data dropped while disabled
    cyc(1, 0, 8'h11, 0, 0, 0, 0, 0, 0, 0);
    chk("R3", "data while disabled", push_valid, 0);
    // R9: disable beats enable
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
    chk("R9", "dis over en", rx_enabled, 0);
    // R6: wake on match, keep=0 strips address
    cfg_wake_mode = 2'b01;
    cyc(1, 1, 8'h5A, 0, 0, 0, 0, 0, 0, 0);
    chk("R6", "wake", rx_enabled, 1);
    chk("R4", "address stripped", push_valid, 0);
    chk("R10", "irq after wake", irq, 1);
    // R8: wake only, mismatch keeps state
    cyc(1, 1, 8'h33, 0, 0, 0, 0, 1, 0, 0);
    chk("R8", "wake-only mismatch", rx_enabled, 1);
    // R12: framing+break carried, R11: full causes overrun
    cyc(1, 0, 8'h77, 1, 1, 0, 0, 0, 0, 0);
    chk("R12", "status flags", push_status, 3'b101);
    cyc(1, 0, 8'h78, 0, 0, 0, 0, 0, 0, 1);
    chk("R11", "overrun set", rx_overrun, 1);
    // R7: doze; R9 host_enable beats doze
    cfg_wake_mode = 2'b10; cfg_keep_addr = 1'b1;
    cyc(1, 1, 8'h34, 0, 0, 1, 0, 0, 0, 0);
    chk("R9", "enable over doze", rx_enabled, 1);
    cyc(1, 1, 8'h34, 1, 0, 0, 0, 0, 0, 0);
    chk("R7", "doze", rx_enabled, 0);
    chk("R12", "addr kept while dozing, flags", push_status, 3'b011);
    // R10: mask
    cfg_irq_mask = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10", "masked irq", irq, 0);
    // R9 / R12: receiver reset clears all and discards char
    cyc(1, 1, 8'h5A, 0, 0, 0, 0, 0, 1, 0);
    chk("R9", "rx reset overrun", rx_overrun, 0);
    chk("R12", "char dropped on rx reset", push_valid, 0);
    cfg_irq_mask = 1'b0;

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic v, a, fe, br, he, hd, hc, hr, full;
      logic [DW-1:0] d;
      if (i % 97 == 0) begin
        cfg_wake_mode = 2'($urandom);
        cfg_keep_addr = 1'($urandom);
      end
      if (i % 41 == 0) cfg_irq_mask = ($urandom % 4) == 0;
      v  = ($urandom % 2) == 0;
      a  = ($urandom % 5) < 2;
      d  = (($urandom % 10) < 3) ? cfg_ref_char : 8'($urandom);
      fe = ($urandom % 8) == 0;
      br = ($urandom % 12) == 0;
      he = ($urandom % 20) == 0;
      hd = ($urandom % 20) == 0;
      hc = ($urandom % 10) == 0;
      hr = ($urandom % 60) == 0;
      full = ($urandom % 7) == 0;
      cyc(v, a, d, fe, br, he, hd, hc, hr, full);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : seed
    void'($urandom(32'd7331));
  end
endmodule